// File: doc/BRIEF.md
# Multi-Lane PRBS Error Checker

This block measures bit error rates on up to eight parallel lanes. Each lane carries a pseudorandom test pattern, and all lanes use the same pattern at a given time. No link bring-up is needed before a test. Each lane delivers a 16-bit word per clock together with a valid strobe. After a test starts, the lane loads its own pattern generator from the first received words. From then on it predicts every following bit and counts each received bit that differs from the prediction.

Software or a test sequencer sets up a test in this order: choose the pattern, set the lane enable mask, pulse the clear input, set an error threshold, and raise the start input. Some time later it lowers start. It then reads a pass/fail bit for each lane. To read one lane's error count, it sets the lane select input and reads the count from the read port.

Top module: `prbs_multi_checker`

## Requirements
- R1: `pat_sel` selects the pattern shared by all lanes: 2'b00 gives x^7+x^6+1 (the value after reset), 2'b01 gives x^15+x^14+1, 2'b10 gives x^31+x^28+1, and the unused code 2'b11 behaves as 2'b00. Within a word, bit 0 is the earliest bit in the sequence and bit 15 is the latest.
- R2: Bit n of `lane_en` enables lane n. A disabled lane never changes its error count, and its status bit reads 0.
- R3: `test_clr` sampled high clears every lane's error count, status bit, synchronisation and running state.
- R4: Counting starts only at a clock edge where `start` is sampled 1 after being 0 at the previous edge. It continues while `start` stays 1 and stops when `start` is sampled 0. If `start` is already 1 when `test_clr` is released, no new test begins.
- R5: After a test starts, the first two valid words on an enabled lane seed its predictor and are not checked. Every later valid word is checked bit by bit.
- R6: Each checked word adds its number of mismatched bits to the lane's count. The count is CNT_W bits wide (24 by default), never decreases except on clear, and saturates at all ones.
- R7: One clock after the count changes, status bit n is 1 exactly when lane n is enabled and its count is less than or equal to `err_thr`.
- R8: `rd_cnt` shows the count of the lane chosen by `rd_sel`, one clock after the select is sampled.
- R9: An error-free pattern leaves every enabled lane at a count of 0. Once a lane is seeded, each flipped bit is counted exactly once, because received errors do not enter the predictor.
- R10: A word whose valid bit is 0 is ignored. It does not advance the predictor and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_clr | input | 1 | Test clear (counts, status, sync, run) |
| start | input | 1 | Test start; a rising edge begins a test |
| pat_sel | input | 2 | Pattern select shared by all lanes |
| lane_en | input | LANES | Per-lane check enable |
| lane_vld | input | LANES | Per-lane word valid |
| lane_data | input | LANES*W | Lane words; lane n in bits [n*W +: W] |
| err_thr | input | CNT_W | Pass threshold (inclusive) |
| rd_sel | input | SEL_W | Lane whose count is read |
| status | output | LANES | 1 = pass, 0 = fail or disabled |
| rd_cnt | output | CNT_W | Error count of the selected lane |

## Verification
The main function is tried with clean streams of all three polynomials. A clean run tells correct tap positions and correct bit order apart from wrong ones, because any mistake in either shows up as a count that is not zero. Next come sparse random bit flips on a random subset of valid words. These show whether each flip is counted once, whether seed words are left unchecked, and whether invalid words are skipped. Flips are also sent on disabled lanes, while the test is stopped, and after a clear with start held high; these confirm that nothing is counted in those cases. Finally, every bit of every word is flipped to drive the count into saturation, and the threshold is set one below and then equal to the count to check the comparison at its boundary.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  typedef enum logic [1:0] {
    PAT_P7  = 2'b00,
    PAT_P15 = 2'b01,
    PAT_P31 = 2'b10,
    PAT_RSV = 2'b11
  } pat_e;

  // longest register length among supported polynomials
  localparam int HIST_W = 31;
  // tap pairs: s[k] = s[k-A] ^ s[k-B]
  localparam int P7_A  = 7;
  localparam int P7_B  = 6;
  localparam int P15_A = 15;
  localparam int P15_B = 14;
  localparam int P31_A = 31;
  localparam int P31_B = 28;
endpackage

// File: rtl/prbs_lane_predict.sv
module prbs_lane_predict
  import prbs_chk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         restart,
  input  logic         seed_ok,
  input  logic [1:0]   pat,
  input  logic         vld,
  input  logic [W-1:0] data,
  output logic         locked,
  output logic [W-1:0] err_bits
);
  localparam int EXT_W      = HIST_W + W;
  localparam int SEED_WORDS = (HIST_W + W - 1) / W;
  localparam int SC_W       = $clog2(SEED_WORDS + 1);

  logic [HIST_W-1:0] hist_q;
  logic [SC_W-1:0]   seed_q;
  logic [EXT_W-1:0]  ext;
  logic [EXT_W-1:0]  rx_ext;
  logic [W-1:0]      pred;

  // oldest bit at index 0, predicted bits appended above the history
  always_comb begin
    ext = {{W{1'b0}}, hist_q};
    for (int i = 0; i < W; i++) begin
      case (pat_e'(pat))
        PAT_P15: ext[HIST_W+i] = ext[HIST_W+i-P15_A] ^ ext[HIST_W+i-P15_B];
        PAT_P31: ext[HIST_W+i] = ext[HIST_W+i-P31_A] ^ ext[HIST_W+i-P31_B];
        default: ext[HIST_W+i] = ext[HIST_W+i-P7_A]  ^ ext[HIST_W+i-P7_B];
      endcase
    end
  end

  assign pred     = ext[EXT_W-1:HIST_W];
  assign rx_ext   = {data, hist_q};
  assign locked   = (seed_q == SC_W'(SEED_WORDS));
  assign err_bits = locked ? (data ^ pred) : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist_q <= '0;
      seed_q <= '0;
    end else begin
      if (restart)
        seed_q <= '0;
      else if (vld && seed_ok && !locked)
        seed_q <= seed_q + 1'b1;
      if (vld)
        hist_q <= locked ? ext[EXT_W-1:W] : rx_ext[EXT_W-1:W];
    end
  end
endmodule

// File: rtl/prbs_err_accum.sv
module prbs_err_accum #(
  parameter int W     = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc_en,
  input  logic [W-1:0]     err_bits,
  output logic [CNT_W-1:0] cnt
);
  localparam int PC_W = $clog2(W + 1);

  logic [PC_W-1:0]  pc;
  logic [CNT_W:0]   sum;

  always_comb begin
    pc = '0;
    for (int i = 0; i < W; i++)
      pc = pc + PC_W'(err_bits[i]);
  end

  assign sum = {1'b0, cnt} + (CNT_W+1)'(pc);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc_en)
      cnt <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/prbs_multi_checker.sv
module prbs_multi_checker #(
  parameter int LANES = 8,
  parameter int W     = 16,
  parameter int CNT_W = 24,
  parameter int SEL_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               test_clr,
  input  logic               start,
  input  logic [1:0]         pat_sel,
  input  logic [LANES-1:0]   lane_en,
  input  logic [LANES-1:0]   lane_vld,
  input  logic [LANES*W-1:0] lane_data,
  input  logic [CNT_W-1:0]   err_thr,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [LANES-1:0]   status,
  output logic [CNT_W-1:0]   rd_cnt
);
  logic start_q;
  logic run_q;
  logic restart;
  logic [LANES-1:0][CNT_W-1:0] lane_cnt;

  assign restart = start && !start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      start_q <= start;
      if (test_clr)
        run_q <= 1'b0;
      else if (restart)
        run_q <= 1'b1;
      else if (!start)
        run_q <= 1'b0;
    end
  end

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic         locked;
    logic [W-1:0] err_bits;

    prbs_lane_predict #(.W(W)) u_pred (
      .clk      (clk),
      .rst      (rst),
      .clr      (test_clr),
      .restart  (restart),
      .seed_ok  (run_q && lane_en[n]),
      .pat      (pat_sel),
      .vld      (lane_vld[n]),
      .data     (lane_data[n*W +: W]),
      .locked   (locked),
      .err_bits (err_bits)
    );

    prbs_err_accum #(.W(W), .CNT_W(CNT_W)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .clr      (test_clr),
      .inc_en   (run_q && lane_en[n] && lane_vld[n] && locked),
      .err_bits (err_bits),
      .cnt      (lane_cnt[n])
    );

    always_ff @(posedge clk) begin
      if (rst || test_clr)
        status[n] <= 1'b0;
      else
        status[n] <= lane_en[n] && (lane_cnt[n] <= err_thr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_cnt <= '0;
    else
      rd_cnt <= lane_cnt[rd_sel];
  end
endmodule

// File: rtl/prbs_multi_checker_sva.sv
module prbs_multi_checker_sva #(
  parameter int LANES = 8,
  parameter int CNT_W = 24,
  parameter int SEL_W = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        test_clr,
  input logic                        start,
  input logic [LANES-1:0]            lane_en,
  input logic [SEL_W-1:0]            rd_sel,
  input logic [LANES-1:0]            status,
  input logic [CNT_W-1:0]            rd_cnt,
  input logic [LANES-1:0][CNT_W-1:0] lane_cnt
);
  assert_clr_status_R3: assert property (@(posedge clk) disable iff (rst)
    $past(test_clr) |-> status == '0);

  assert_clr_readout_R3: assert property (@(posedge clk) disable iff (rst)
    $past(test_clr, 2) |-> rd_cnt == '0);

  assert_disabled_fail_R2: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(lane_en)) == '0);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    rd_cnt == $past(lane_cnt[rd_sel]));

  for (genvar n = 0; n < LANES; n++) begin : g_chk
    assert_no_decrease_R6: assert property (@(posedge clk) disable iff (rst)
      !test_clr |=> lane_cnt[n] >= $past(lane_cnt[n]));

    assert_stop_freeze_R4: assert property (@(posedge clk) disable iff (rst)
      (!start && !$past(start) && !test_clr) |=> $stable(lane_cnt[n]));

    assert_off_lane_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!lane_en[n] && !test_clr) |=> $stable(lane_cnt[n]));
  end
endmodule

bind prbs_multi_checker prbs_multi_checker_sva #(
  .LANES(LANES), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_sva (
  .clk      (clk),
  .rst      (rst),
  .test_clr (test_clr),
  .start    (start),
  .lane_en  (lane_en),
  .rd_sel   (rd_sel),
  .status   (status),
  .rd_cnt   (rd_cnt),
  .lane_cnt (lane_cnt)
);

// File: tb/prbs_multi_checker_tb.sv
`timescale 1ns/1ps
module prbs_multi_checker_tb;
  localparam int LANES = 8;
  localparam int W     = 16;
  localparam int CNT_W = 10;
  localparam int SEL_W = 3;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               test_clr = 1'b0;
  logic               start = 1'b0;
  logic [1:0]         pat_sel = 2'b00;
  logic [LANES-1:0]   lane_en = '0;
  logic [LANES-1:0]   lane_vld = '0;
  logic [LANES*W-1:0] lane_data = '0;
  logic [CNT_W-1:0]   err_thr = '0;
  logic [SEL_W-1:0]   rd_sel = '0;
  logic [LANES-1:0]   status;
  logic [CNT_W-1:0]   rd_cnt;

  prbs_multi_checker #(.LANES(LANES), .W(W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_dut (
    .clk(clk), .rst(rst), .test_clr(test_clr), .start(start), .pat_sel(pat_sel),
    .lane_en(lane_en), .lane_vld(lane_vld), .lane_data(lane_data),
    .err_thr(err_thr), .rd_sel(rd_sel), .status(status), .rd_cnt(rd_cnt)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [30:0] gen_st [LANES];
  int          exp_cnt [LANES];
  int          seen [LANES];
  bit          running = 1'b0;

  function automatic logic [46:0] gen_step(logic [30:0] st, logic [1:0] p);
    logic [15:0] w;
    logic b;
    for (int i = 0; i < 16; i++) begin
      case (p)
        2'b01:   b = st[14] ^ st[13];
        2'b10:   b = st[30] ^ st[27];
        default: b = st[6] ^ st[5];
      endcase
      w[i] = b;
      st = {st[29:0], b};
    end
    return {w, st};
  endfunction

  function automatic int ones16(logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic reseed();
    for (int l = 0; l < LANES; l++) gen_st[l] = 31'($urandom) | 31'h1;
  endtask

  task automatic do_clear();
    @(negedge clk);
    lane_vld = '0;
    test_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    test_clr = 1'b0;
    running = start;
    running = 1'b0;
    for (int l = 0; l < LANES; l++) begin exp_cnt[l] = 0; seen[l] = 0; end
  endtask

  task automatic begin_test();
    @(negedge clk);
    lane_vld = '0;
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    running = 1'b1;
    for (int l = 0; l < LANES; l++) seen[l] = 0;
  endtask

  task automatic end_test();
    @(negedge clk);
    lane_vld = '0;
    start = 1'b0;
    @(posedge clk);
    running = 1'b0;
  endtask

  // mode 0: clean, 1: sparse flips, 2: every bit flipped
  task automatic send_words(input int n, input int mode, input bit all_vld);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        logic [46:0] r;
        logic [15:0] em;
        bit v;
        bit chk;
        v = all_vld || ($urandom % 4 != 0);
        lane_vld[l] = v;
        if (v) begin
          r = gen_step(gen_st[l], pat_sel);
          gen_st[l] = r[30:0];
          chk = running && lane_en[l] && (seen[l] >= 2);
          em = '0;
          if (mode == 2 && (chk || !lane_en[l] || !running)) em = 16'hFFFF;
          else if (mode == 1 && (chk || !lane_en[l] || !running))
            em = 16'($urandom & $urandom & $urandom & $urandom);
          if (running && lane_en[l]) begin
            if (chk) begin
              exp_cnt[l] += ones16(em);
              if (exp_cnt[l] > MAXC) exp_cnt[l] = MAXC;
            end
            seen[l]++;
          end
          lane_data[l*W +: W] = r[46:31] ^ em;
        end else begin
          lane_data[l*W +: W] = 16'($urandom);
        end
      end
      @(posedge clk);
    end
    @(negedge clk);
    lane_vld = '0;
  endtask

  task automatic check_lanes(input string req);
    @(negedge clk);
    lane_vld = '0;
    for (int l = 0; l < LANES; l++) begin
      @(negedge clk);
      rd_sel = SEL_W'(l);
      @(posedge clk);
      @(negedge clk);
      check(int'(rd_cnt) == exp_cnt[l], req, int'(rd_cnt), exp_cnt[l]);
    end
  endtask

  task automatic check_status(input string req);
    logic [LANES-1:0] e;
    @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) e[l] = lane_en[l] && (exp_cnt[l] <= int'(err_thr));
    check(status == e, req, int'(status), int'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    reseed();
    for (int l = 0; l < LANES; l++) begin exp_cnt[l] = 0; seen[l] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(status == '0, "R3 reset status", int'(status), 0);
    check(rd_cnt == '0, "R8 reset readout", int'(rd_cnt), 0);

    // R9 R1: clean PRBS7 on all lanes, zero threshold
    pat_sel = 2'b00; lane_en = '1; err_thr = '0;
    do_clear(); reseed(); begin_test();
    send_words(40, 0, 1'b1);
    check_lanes("R9 clean x7");
    check_status("R7 clean pass");

    // R1 R6 R10: PRBS15, sparse flips, random valid
    pat_sel = 2'b01; err_thr = CNT_W'(6);
    do_clear(); reseed(); begin_test();
    send_words(60, 1, 1'b0);
    check_lanes("R6 R10 x15 flips");
    check_status("R7 x15 threshold");

    // R1 R5 R2: PRBS31, subset enabled, flips on every lane
    pat_sel = 2'b10; lane_en = 8'b1010_0110; err_thr = CNT_W'(8);
    do_clear(); reseed(); begin_test();
    send_words(60, 1, 1'b0);
    check_lanes("R5 R2 x31 subset");
    check_status("R2 disabled lanes fail");

    // R4: stopped test counts nothing
    end_test();
    send_words(20, 1, 1'b1);
    check_lanes("R4 stop freezes");

    // R4 R3: clear while start held high; no new test without a rising edge
    lane_en = '1;
    begin_test();
    send_words(20, 1, 1'b1);
    @(negedge clk);
    test_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    test_clr = 1'b0;
    running = 1'b0;
    for (int l = 0; l < LANES; l++) begin exp_cnt[l] = 0; seen[l] = 0; end
    send_words(20, 1, 1'b1);
    check_lanes("R3 R4 clear with start high");

    // R1 R6 R7: reserved code acts as x7; saturation and threshold boundary
    pat_sel = 2'b11; lane_en = '1; err_thr = CNT_W'(MAXC - 1);
    do_clear(); reseed(); begin_test();
    send_words(80, 2, 1'b1);
    check_lanes("R6 saturation");
    check_status("R7 one below count");
    @(negedge clk);
    err_thr = CNT_W'(MAXC);
    check_status("R7 equal to count");

    end_test();
    finish_run();
  end
endmodule